// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block governs the operating modes of a CAN controller core. When the module enable is first seen high, it zero-fills the controller's message RAM through a one-word-per-cycle write port. A busy flag is shown for the whole fill. Until the fill is over, the block refuses every mode request.

After that, software moves a global state and one channel state between stop, reset and run modes by writing request fields. The block confirms each change through status outputs. A pending flag covers the fixed transition delay. Once the channel runs, the block watches the sampled receive bit together with its bit strobe. When it sees enough consecutive recessive bits, it raises a communication-ready flag. From that point the node may transmit and receive as an active participant.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, both mode outputs read stop (2'b10), and the two pending flags, com_ready, ram_init_busy and ram_we are all 0.
- R2: When mod_en is sampled high for the first time, ram_init_busy and ram_we go to 1 for exactly 276 cycles. In those cycles ram_addr steps through 0 to 275, one per cycle, and ram_wdata is 0. A later mod_en has no effect.
- R3: A request written before the RAM fill has completed is ignored. This covers requests before mod_en and requests while busy. Both mode outputs stay at stop and no pending flag is set.
- R4: Mode codes are run 2'b00, reset 2'b01 and stop 2'b10. A select value of 2'b00 asks for run, and any other select value asks for reset. For the global state the moves are as follows:
  - From stop, a write with sleep=0 moves to reset. A write with sleep=1 asks for stop and causes no change.
  - From reset, sleep=1 moves to stop. Sleep=0 with select 2'b00 moves to run.
  - From run, any write other than sleep=0 with select 2'b00 moves to reset.
- R5: The channel follows the same rules as R4 with one addition. It enters run only if the global mode is run both when the request is written and when the change completes. Otherwise the channel stays in reset.
- R6: An accepted request sets the pending flag after the write edge. The mode output changes on the second edge after the write edge, and pending clears on that same edge. A write that asks for the current mode sets no pending flag.
- R7: Writes to a state while its pending flag is set are ignored.
- R8: While the channel is in run, com_ready rises on the edge that samples the 11th consecutive recessive bit. A recessive bit is rx_bit=1 with bit_stb=1. A dominant bit (rx_bit=0 with bit_stb=1) restarts the count, and cycles with bit_stb=0 do not count.
- R9: Once set, com_ready ignores dominant bits. It clears on the same edge that the channel leaves run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; starts the RAM fill |
| g_wr | input | 1 | Global request write strobe |
| g_sleep | input | 1 | Global sleep request |
| g_sel | input | 2 | Global mode select (00 run, other reset) |
| c_wr | input | 1 | Channel request write strobe |
| c_sleep | input | 1 | Channel sleep request |
| c_sel | input | 2 | Channel mode select (00 run, other reset) |
| bit_stb | input | 1 | Marks a sampled receive bit |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| g_mode | output | 2 | Current global mode |
| g_pend | output | 1 | Global change in progress |
| c_mode | output | 2 | Current channel mode |
| c_pend | output | 1 | Channel change in progress |
| com_ready | output | 1 | Channel ready for bus traffic |
| ram_init_busy | output | 1 | RAM fill in progress |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM write address |
| ram_wdata | output | 32 | RAM write data |

## Verification
Every result is registered. Pending flags and the RAM signals appear one edge after the stimulus that causes them. Mode outputs move on the second edge after an accepted write. com_ready rises one edge after the 11th recessive strobe and falls with the mode change. The bench drives inputs and reads outputs at falling edges. A cycle model written from the requirements is advanced once per rising edge, so each comparison sits exactly at the edge where a result is due. Directed sequences add explicit expected values for the pending window, requests written during a pending change, the held channel request, and a dominant bit arriving at a count of 10.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_RESET = 2'b01,
    MODE_STOP  = 2'b10
  } mode_e;

  localparam logic [1:0] SEL_RUN = 2'b00;

endpackage

// File: rtl/can_ram_clear.sv
module can_ram_clear #(
  parameter int WORDS = 276,
  parameter int AW    = $clog2(WORDS),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          upd;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    addr_d = addr_q;
    if (busy_q) begin
      if (addr_q == LAST_ADDR) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        addr_d = '0;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end else if (start && !done_q) begin
      busy_d = 1'b1;
      addr_d = '0;
    end
  end

  assign upd = busy_q || (start && !done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      done_q <= done_d;
      addr_q <= addr_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign addr  = addr_q;
  assign wdata = '0;

  AST_FILL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !done_q) else $error("fill restarted"); // R2

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sleep,
  input  logic [1:0] sel,
  input  logic       lock,
  input  logic       allow_run,
  output mode_e      cur,
  output mode_e      nxt,
  output logic       pend
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  mode_e         cur_q, cur_d, tgt_q, tgt_d, req;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  always_comb begin
    unique case (cur_q)
      MODE_STOP:  req = sleep ? MODE_STOP : MODE_RESET;
      MODE_RESET: req = sleep ? MODE_STOP :
                        ((sel == SEL_RUN && allow_run) ? MODE_RUN : MODE_RESET);
      default:    req = (!sleep && sel == SEL_RUN) ? MODE_RUN : MODE_RESET;
    endcase
  end

  assign accept = wr && !lock && !pend_q && (req != cur_q);

  always_comb begin
    cur_d  = cur_q;
    tgt_d  = tgt_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (pend_q) begin
      if (cnt_q == LAST) begin
        pend_d = 1'b0;
        cnt_d  = '0;
        cur_d  = (tgt_q == MODE_RUN && !allow_run) ? MODE_RESET : tgt_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (accept) begin
      pend_d = 1'b1;
      tgt_d  = req;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= MODE_STOP;
      tgt_q  <= MODE_STOP;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q || accept) begin
      cur_q  <= cur_d;
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur  = cur_q;
  assign nxt  = (pend_q || accept) ? cur_d : cur_q;
  assign pend = pend_q;

  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_q) == MODE_STOP && cur_q != MODE_STOP) |-> cur_q == MODE_RESET)
    else $error("stop left to non-reset"); // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) && pend_q) |-> $stable(cur_q) && $stable(tgt_q))
    else $error("mode moved while pending"); // R7

  AST_LOCK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock) && !$past(pend_q)) |-> !pend_q)
    else $error("pending while locked"); // R3

endmodule

// File: rtl/can_idle_det.sv
module can_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic stay_run,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic ready
);

  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!stay_run) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (in_run && !rdy_q && bit_stb) begin
      if (!rx_bit) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  AST_READY_ON_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(bit_stb && rx_bit)) else $error("ready without recessive bit"); // R8

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RAM_WORDS = 276,
  parameter int DW        = 32,
  parameter int LAT       = 2,
  parameter int IDLE_BITS = 11,
  localparam int AW       = $clog2(RAM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic          g_wr,
  input  logic          g_sleep,
  input  logic [1:0]    g_sel,
  input  logic          c_wr,
  input  logic          c_sleep,
  input  logic [1:0]    c_sel,
  input  logic          bit_stb,
  input  logic          rx_bit,
  output logic [1:0]    g_mode,
  output logic          g_pend,
  output logic [1:0]    c_mode,
  output logic          c_pend,
  output logic          com_ready,
  output logic          ram_init_busy,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic  fill_busy, fill_done;
  mode_e g_cur, g_nxt, c_cur, c_nxt;

  can_ram_clear #(.WORDS(RAM_WORDS), .AW(AW), .DW(DW)) i_fill (
    .clk(clk), .rst_n(rst_ni), .start(mod_en),
    .busy(fill_busy), .done(fill_done), .addr(ram_addr), .wdata(ram_wdata)
  );

  can_mode_fsm #(.LAT(LAT)) i_gfsm (
    .clk(clk), .rst_n(rst_ni), .wr(g_wr), .sleep(g_sleep), .sel(g_sel),
    .lock(!fill_done), .allow_run(1'b1),
    .cur(g_cur), .nxt(g_nxt), .pend(g_pend)
  );

  can_mode_fsm #(.LAT(LAT)) i_cfsm (
    .clk(clk), .rst_n(rst_ni), .wr(c_wr), .sleep(c_sleep), .sel(c_sel),
    .lock(!fill_done), .allow_run(g_cur == MODE_RUN),
    .cur(c_cur), .nxt(c_nxt), .pend(c_pend)
  );

  can_idle_det #(.IDLE_BITS(IDLE_BITS)) i_idle (
    .clk(clk), .rst_n(rst_ni),
    .in_run(c_cur == MODE_RUN), .stay_run(c_nxt == MODE_RUN),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .ready(com_ready)
  );

  assign g_mode        = g_cur;
  assign c_mode        = c_cur;
  assign ram_init_busy = fill_busy;
  assign ram_we        = fill_busy;

  AST_LOCKED_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_busy |-> (g_mode == MODE_STOP && g_nxt == MODE_STOP && c_mode == MODE_STOP))
    else $error("mode left stop during fill"); // R3

  AST_RUN_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_ni)
    (c_mode == MODE_RUN && $past(c_mode) != MODE_RUN) |-> $past(g_mode) == MODE_RUN)
    else $error("channel ran without global run"); // R5

  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_ni)
    com_ready |-> c_mode == MODE_RUN) else $error("ready outside run"); // R9

endmodule

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;

  localparam int RUN = 0, RST = 1, STP = 2;

  logic clk, rst_n, mod_en, g_wr, g_sleep, c_wr, c_sleep, bit_stb, rx_bit;
  logic [1:0] g_sel, c_sel, g_mode, c_mode;
  logic g_pend, c_pend, com_ready, ram_init_busy, ram_we;
  logic [8:0] ram_addr;
  logic [31:0] ram_wdata;

  can_mode_seq i_can_mode_seq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int mg, mgp, mgc, mgt, mc, mcp, mcc, mct, mrc, mrdy, mb, md, ma;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int req_of(int cur, bit sl, logic [1:0] se, bit allow);
    if (cur == STP) return sl ? STP : RST;
    if (cur == RST) return sl ? STP : ((se == 2'b00 && allow) ? RUN : RST);
    return (!sl && se == 2'b00) ? RUN : RST;
  endfunction

  task automatic fsm_step(inout int cur, pend, cnt, tgt,
                          input bit wr, bit sl, logic [1:0] se, bit lock, bit allow);
    int r;
    r = req_of(cur, sl, se, allow);
    if (pend) begin
      if (cnt == 1) begin
        pend = 0; cnt = 0;
        cur = (tgt == RUN && !allow) ? RST : tgt;
      end else cnt++;
    end else if (wr && !lock && r != cur) begin
      pend = 1; tgt = r; cnt = 0;
    end
  endtask

  task automatic model_reset();
    mg = STP; mgp = 0; mgc = 0; mgt = STP;
    mc = STP; mcp = 0; mcc = 0; mct = STP;
    mrc = 0; mrdy = 0; mb = 0; md = 0; ma = 0;
  endtask

  task automatic cyc(bit en, bit gw, bit gs, logic [1:0] gse,
                     bit cw, bit cs, logic [1:0] cse, bit stb, bit bt);
    int pg, pc, ob, od;
    mod_en = en; g_wr = gw; g_sleep = gs; g_sel = gse;
    c_wr = cw; c_sleep = cs; c_sel = cse; bit_stb = stb; rx_bit = bt;
    pg = mg; pc = mc; ob = mb; od = md;
    if (mb) begin
      if (ma == 275) begin mb = 0; md = 1; ma = 0; end
      else ma++;
    end else if (en && !md) begin mb = 1; ma = 0; end
    fsm_step(mg, mgp, mgc, mgt, gw, gs, gse, !od, 1'b1);
    fsm_step(mc, mcp, mcc, mct, cw, cs, cse, !od, pg == RUN);
    if (mc != RUN) begin mrc = 0; mrdy = 0; end
    else if (pc == RUN && !mrdy && stb) begin
      if (!bt) mrc = 0;
      else if (mrc == 10) mrdy = 1;
      else mrc++;
    end
    @(negedge clk);
    chk("R4 g_mode", g_mode, mg);
    chk("R5 c_mode", c_mode, mc);
    chk("R6 g_pend", g_pend, mgp);
    chk("R6 c_pend", c_pend, mcp);
    chk("R8 com_ready", com_ready, mrdy);
    chk("R2 busy", ram_init_busy, mb);
    chk("R2 we", ram_we, mb);
    if (mb) chk("R2 addr", ram_addr, ma);
    chk("R2 wdata", (ram_wdata == 0) ? 1 : 0, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'b11, 0, 0, 2'b11, 0, 1);
  endtask

  task automatic gw(bit sl, logic [1:0] se);
    cyc(0, 1, sl, se, 0, 0, 2'b11, 0, 1);
  endtask

  task automatic cw(bit sl, logic [1:0] se);
    cyc(0, 0, 0, 2'b11, 1, sl, se, 0, 1);
  endtask

  task automatic rbit(bit b);
    cyc(0, 0, 0, 2'b11, 0, 0, 2'b11, 1, b);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, busy_cnt;
    seed = 32'h5EED;
    void'($urandom(seed));
    {mod_en, g_wr, g_sleep, c_wr, c_sleep, bit_stb, rx_bit} = '0;
    g_sel = 2'b11; c_sel = 2'b11;
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    chk("R1 g_mode", g_mode, STP);
    chk("R1 c_mode", c_mode, STP);
    chk("R1 pend", {g_pend, c_pend}, 0);
    chk("R1 ready", com_ready, 0);
    chk("R1 busy", {ram_init_busy, ram_we}, 0);

    // R3 request before enable
    gw(0, 2'b00);
    idle(3);
    chk("R3 pre-enable g_mode", g_mode, STP);

    // R2 fill length, R3 request while busy
    cyc(1, 0, 0, 2'b11, 0, 0, 2'b11, 0, 1);
    busy_cnt = ram_init_busy;
    gw(0, 2'b01);
    busy_cnt += ram_init_busy;
    cw(0, 2'b00);
    busy_cnt += ram_init_busy;
    chk("R3 busy g_pend", g_pend, 0);
    while (ram_init_busy) begin
      cyc(1, 0, 0, 2'b11, 0, 0, 2'b11, 0, 1);
      busy_cnt += ram_init_busy;
    end
    chk("R2 fill cycles", busy_cnt, 276);
    chk("R3 after fill g_mode", g_mode, STP);
    idle(2);
    chk("R2 no refill", ram_init_busy, 0);

    // R6 timing, global stop -> reset
    gw(0, 2'b11);
    chk("R6 pend after write", g_pend, 1);
    chk("R6 mode held", g_mode, STP);
    idle(1);
    chk("R6 mode held 2", g_mode, STP);
    idle(1);
    chk("R6 mode applied", g_mode, RST);
    chk("R6 pend cleared", g_pend, 0);
    gw(0, 2'b01);
    chk("R6 no-change write", g_pend, 0);

    // R5 channel to reset, then run request held while global in reset
    cw(0, 2'b01); idle(2);
    chk("R5 channel reset", c_mode, RST);
    cw(0, 2'b00); idle(2);
    chk("R5 held in reset", c_mode, RST);
    chk("R5 no pending", c_pend, 0);

    // R7 write during pending ignored
    gw(0, 2'b00);
    gw(1, 2'b01);
    idle(3);
    chk("R7 global run kept", g_mode, RUN);

    // channel to run, R8 count
    cw(0, 2'b00); idle(2);
    chk("R5 channel run", c_mode, RUN);
    chk("R8 not ready yet", com_ready, 0);
    for (int i = 0; i < 10; i++) begin rbit(1); idle(1); end
    rbit(0);
    chk("R8 dominant at 10", com_ready, 0);
    for (int i = 0; i < 10; i++) rbit(1);
    chk("R8 ten recessive", com_ready, 0);
    rbit(1);
    chk("R8 eleventh recessive", com_ready, 1);
    rbit(0);
    chk("R9 dominant after ready", com_ready, 1);

    // R9 leaving run clears ready with the mode change
    cw(0, 2'b01);
    idle(1);
    chk("R9 ready during pend", com_ready, 1);
    idle(1);
    chk("R9 mode left", c_mode, RST);
    chk("R9 ready cleared", com_ready, 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      bit a, b, gs, cs;
      logic [1:0] ge, ce;
      a  = ($urandom % 4) == 0;
      b  = ($urandom % 3) == 0;
      gs = ($urandom % 8) == 0;
      cs = ($urandom % 8) == 0;
      ge = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      ce = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 50) == 0) begin ge = 2'b01; ce = 2'b01; end
      cyc($urandom % 2, a, gs, ge, b, cs, ce, $urandom % 2, ($urandom % 16) != 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule